// File: doc/BRIEF.md
# Toroidal Life Grid Engine

This block keeps a 20 by 15 field of one-bit cells and advances it one generation of the classic birth-and-survival automaton each time it is asked. It holds two copies of the field. One copy is the displayed generation and the other is a scratch copy. A single step pulse makes the engine visit every cell once, one per clock, in row-major order. For each cell it gathers the eight surrounding cells, counts the live ones, applies the rule, and writes the result into the scratch copy. After the last cell the roles of the two copies swap, and the engine raises a one-cycle completion pulse.

The field has no edges. The column to the left of column 0 is column 19, the row above row 0 is row 14, and the same holds at the corners. A cell is loaded through a small valid/ready write channel. The channel is ready only while the engine is idle. A beat presented while ready is low is dropped, not held, so a producer must keep `load_valid` asserted until it sees `load_ready` high at a clock edge. A combinational read port turns a screen pixel position into the colour of the cell under it. This port always shows the copy that is current, so the picture changes only at the swap.

Top module: `life_engine`

## Requirements
- R1: During a generation, a live cell with two or three live neighbours is live in the next generation.
- R2: A live cell with zero or one live neighbour, or with four to eight, is dead in the next generation.
- R3: A dead cell becomes live when exactly three neighbours are live. With any other count it stays dead.
- R4: Neighbours wrap on every side: column 0 and column 19 are adjacent, row 0 and row 14 are adjacent, and corner cells see the three opposite corners.
- R5: Every new cell value is computed from the previous generation only, so cells already updated in the walk never feed later cells of the same walk.
- R6: The pixel port takes the cell column from pix_x[9:5] and the cell row from pix_y[8:5]. A live cell reads 3'b000 and a dead cell reads 3'b111. A column of 20 or more, a row of 15 or more, or pix_y[9] set reads 3'b111.
- R7: While a walk runs, the pixel port shows the old generation. The new one appears only after the swap.
- R8: A step pulse taken while idle sets busy on the next edge. done is high for exactly one cycle, set on the 300th clock edge after the edge that accepted the step, together with the swap and the fall of busy.
- R9: A step pulse while busy is ignored. The walk neither restarts nor repeats.
- R10: load_ready equals not busy. A beat with load_valid and load_ready writes load_alive into the current copy at (load_col, load_row). A beat offered while busy changes nothing.
- R11: A synchronous reset clears both copies, leaves the engine idle, and holds done low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| step | input | 1 | One-cycle request to compute the next generation |
| busy | output | 1 | High while the walk runs |
| done | output | 1 | One-cycle pulse after the swap |
| load_valid | input | 1 | Cell write beat offered |
| load_ready | output | 1 | Write channel can accept (engine idle) |
| load_col | input | 5 | Column of the cell to write, 0..19 |
| load_row | input | 4 | Row of the cell to write, 0..14 |
| load_alive | input | 1 | Value to write, 1 = live |
| pix_x | input | 10 | Pixel column |
| pix_y | input | 10 | Pixel row |
| pix_rgb | output | 3 | Colour of the addressed cell |

## Verification
The engine is tried with a still interior oscillator, with oscillators and a still block placed across each edge and across the four corners, with a glider that travels through the wrap for many generations, with a pseudo-random field at about one-third density, and with a fully live field. The wrapped patterns separate correct toroidal addressing from clamped or off-by-one addressing. The random field reaches every neighbour count and so separates each rule branch. The oscillators and the glider expose any in-place update, because a cell changed early in the walk would corrupt later ones. During walks the bench probes the pixel port and tries stray step and load beats, and it times the done pulse against the cell count.

// File: rtl/life_pkg.sv
package life_pkg;
  localparam int NB     = 8;
  localparam int CNT_W  = 4;
  localparam int NB_DX [NB] = '{-1, 0, 1, -1, 1, -1, 0, 1};
  localparam int NB_DY [NB] = '{-1, -1, -1, 0, 0, 1, 1, 1};
  localparam logic [2:0] RGB_LIVE = 3'b000;
  localparam logic [2:0] RGB_DEAD = 3'b111;
endpackage

// File: rtl/life_nbr_addr.sv
module life_nbr_addr
  import life_pkg::*;
#(
  parameter int COLS = 20,
  parameter int ROWS = 15
) (
  input  logic [$clog2(COLS)-1:0]         col,
  input  logic [$clog2(ROWS)-1:0]         row,
  output logic [NB-1:0][$clog2(COLS)-1:0] nb_col,
  output logic [NB-1:0][$clog2(ROWS)-1:0] nb_row
);
  localparam int CW = $clog2(COLS);
  localparam int RW = $clog2(ROWS);

  logic [CW-1:0] col_lo, col_hi;
  logic [RW-1:0] row_lo, row_hi;

  // explicit compares at both ends, no power-of-two modulo
  always_comb begin
    col_lo = (col == '0) ? CW'(COLS - 1) : col - CW'(1);
    col_hi = (col == CW'(COLS - 1)) ? '0 : col + CW'(1);
    row_lo = (row == '0) ? RW'(ROWS - 1) : row - RW'(1);
    row_hi = (row == RW'(ROWS - 1)) ? '0 : row + RW'(1);
  end

  for (genvar k = 0; k < NB; k++) begin : g_nb
    if (NB_DX[k] < 0) begin : g_xl
      assign nb_col[k] = col_lo;
    end else if (NB_DX[k] > 0) begin : g_xh
      assign nb_col[k] = col_hi;
    end else begin : g_xm
      assign nb_col[k] = col;
    end
    if (NB_DY[k] < 0) begin : g_yl
      assign nb_row[k] = row_lo;
    end else if (NB_DY[k] > 0) begin : g_yh
      assign nb_row[k] = row_hi;
    end else begin : g_ym
      assign nb_row[k] = row;
    end
  end
endmodule

// File: rtl/life_popcount.sv
module life_popcount
  import life_pkg::*;
(
  input  logic [NB-1:0]    bits,
  output logic [CNT_W-1:0] count
);
  always_comb begin
    count = '0;
    for (int k = 0; k < NB; k++) begin
      count = count + CNT_W'(bits[k]);
    end
  end
endmodule

// File: rtl/life_rule.sv
module life_rule
  import life_pkg::*;
(
  input  logic             alive,
  input  logic [CNT_W-1:0] count,
  output logic             next_alive
);
  always_comb begin
    unique case (count)
      CNT_W'(3): next_alive = 1'b1;
      CNT_W'(2): next_alive = alive;
      default:   next_alive = 1'b0;
    endcase
  end
endmodule

// File: rtl/life_engine.sv
module life_engine
  import life_pkg::*;
#(
  parameter int COLS       = 20,
  parameter int ROWS       = 15,
  parameter int CELL_SHIFT = 5,
  parameter int PIX_W      = 10
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    step,
  output logic                    busy,
  output logic                    done,
  input  logic                    load_valid,
  output logic                    load_ready,
  input  logic [$clog2(COLS)-1:0] load_col,
  input  logic [$clog2(ROWS)-1:0] load_row,
  input  logic                    load_alive,
  input  logic [PIX_W-1:0]        pix_x,
  input  logic [PIX_W-1:0]        pix_y,
  output logic [2:0]              pix_rgb
);
  localparam int CW    = $clog2(COLS);
  localparam int RW    = $clog2(ROWS);
  localparam int CELLS = COLS * ROWS;
  localparam int IW    = $clog2(CELLS);
  localparam int YTOP  = CELL_SHIFT + RW;

  // two generation copies; cur_sel names the displayed one
  logic [CELLS-1:0] bank_q [2];
  logic             cur_sel;
  logic [CELLS-1:0] cur_bank;
  assign cur_bank = bank_q[cur_sel];

  // walk position
  logic [CW-1:0] walk_col;
  logic [RW-1:0] walk_row;
  logic [IW-1:0] walk_idx;
  logic          last_cell;
  assign walk_idx  = IW'(walk_row) * IW'(COLS) + IW'(walk_col);
  assign last_cell = (walk_col == CW'(COLS - 1)) && (walk_row == RW'(ROWS - 1));

  // neighbourhood of the walk cell
  logic [NB-1:0][CW-1:0] nb_col;
  logic [NB-1:0][RW-1:0] nb_row;
  logic [NB-1:0]         nb_bits;
  logic [CNT_W-1:0]      nb_count;
  logic                  next_alive;

  life_nbr_addr #(.COLS(COLS), .ROWS(ROWS)) u_addr (
    .col    (walk_col),
    .row    (walk_row),
    .nb_col (nb_col),
    .nb_row (nb_row)
  );

  for (genvar k = 0; k < NB; k++) begin : g_fetch
    logic [IW-1:0] nb_idx;
    assign nb_idx     = IW'(nb_row[k]) * IW'(COLS) + IW'(nb_col[k]);
    assign nb_bits[k] = cur_bank[nb_idx];
  end

  life_popcount u_count (
    .bits  (nb_bits),
    .count (nb_count)
  );

  life_rule u_rule (
    .alive      (cur_bank[walk_idx]),
    .count      (nb_count),
    .next_alive (next_alive)
  );

  // load channel
  logic          load_fire;
  logic          load_in_range;
  logic [IW-1:0] load_idx;
  assign load_ready    = !busy;
  assign load_in_range = (load_col < CW'(COLS)) && (load_row < RW'(ROWS));
  assign load_fire     = load_valid && load_ready && load_in_range;
  assign load_idx      = IW'(load_row) * IW'(COLS) + IW'(load_col);

  // sequencer and storage
  always_ff @(posedge clk) begin
    if (rst) begin
      bank_q[0] <= '0;
      bank_q[1] <= '0;
      cur_sel   <= 1'b0;
      busy      <= 1'b0;
      done      <= 1'b0;
      walk_col  <= '0;
      walk_row  <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (load_fire) begin
          bank_q[cur_sel][load_idx] <= load_alive;
        end
        if (step) begin
          busy     <= 1'b1;
          walk_col <= '0;
          walk_row <= '0;
        end
      end else begin
        bank_q[!cur_sel][walk_idx] <= next_alive;
        if (last_cell) begin
          busy     <= 1'b0;
          cur_sel  <= !cur_sel;
          done     <= 1'b1;
          walk_col <= '0;
          walk_row <= '0;
        end else if (walk_col == CW'(COLS - 1)) begin
          walk_col <= '0;
          walk_row <= walk_row + RW'(1);
        end else begin
          walk_col <= walk_col + CW'(1);
        end
      end
    end
  end

  // pixel lookup
  logic [CW-1:0] pix_col;
  logic [RW-1:0] pix_row;
  logic          pix_in_range;
  logic [IW-1:0] pix_idx;
  logic          pix_unused;
  assign pix_col      = pix_x[CELL_SHIFT +: CW];
  assign pix_row      = pix_y[CELL_SHIFT +: RW];
  assign pix_in_range = (pix_col < CW'(COLS)) && (pix_row < RW'(ROWS)) &&
                        (pix_y[PIX_W-1:YTOP] == '0);
  assign pix_idx      = pix_in_range ? (IW'(pix_row) * IW'(COLS) + IW'(pix_col)) : '0;
  assign pix_rgb      = (pix_in_range && cur_bank[pix_idx]) ? RGB_LIVE : RGB_DEAD;
  assign pix_unused   = ^{pix_x[CELL_SHIFT-1:0], pix_y[CELL_SHIFT-1:0]};

  // assertions
  AST_STEP_STARTS_WALK: assert property (@(posedge clk) disable iff (rst)
    (!busy && step) |=> busy);                                   // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);                                             // R8
  AST_DONE_AFTER_WALK: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));                            // R8
  AST_WALK_ADVANCES: assert property (@(posedge clk) disable iff (rst)
    (busy && !last_cell) |=> (busy && walk_idx == $past(walk_idx) + IW'(1))); // R9
  AST_NO_LOAD_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy |-> !load_ready);                                       // R10
  AST_VIEW_STABLE: assert property (@(posedge clk) disable iff (rst)
    (busy && !last_cell) |=> $stable(cur_sel));                  // R7
  AST_IDLE_VIEW_STABLE: assert property (@(posedge clk) disable iff (rst)
    !busy |=> $stable(cur_sel));                                 // R7
  AST_LIVE_COUNT: assert property (@(posedge clk) disable iff (rst)
    (busy && next_alive) |-> (nb_count == CNT_W'(2) || nb_count == CNT_W'(3))); // R1
  AST_BIRTH: assert property (@(posedge clk) disable iff (rst)
    (busy && nb_count == CNT_W'(3)) |-> next_alive);             // R3
endmodule

// File: tb/test_life_engine.sv
`timescale 1ns/1ps
module test_life_engine;
  localparam int COLS  = 20;
  localparam int ROWS  = 15;
  localparam int CELLS = COLS * ROWS;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       step = 1'b0;
  logic       busy, done;
  logic       load_valid = 1'b0;
  logic       load_ready;
  logic [4:0] load_col = '0;
  logic [3:0] load_row = '0;
  logic       load_alive = 1'b0;
  logic [9:0] pix_x = '0;
  logic [9:0] pix_y = '0;
  logic [2:0] pix_rgb;

  always #2 clk = ~clk;

  life_engine i_life_engine (
    .clk(clk), .rst(rst), .step(step), .busy(busy), .done(done),
    .load_valid(load_valid), .load_ready(load_ready), .load_col(load_col),
    .load_row(load_row), .load_alive(load_alive),
    .pix_x(pix_x), .pix_y(pix_y), .pix_rgb(pix_rgb)
  );

  int errors = 0;
  int checks = 0;
  int g    [ROWS][COLS];
  int snap [ROWS][COLS];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  task automatic clear_model();
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) g[r][c] = 0;
  endtask

  task automatic model_step();
    int nx [ROWS][COLS];
    for (int r = 0; r < ROWS; r++) begin
      for (int c = 0; c < COLS; c++) begin
        int n = 0;
        for (int dr = -1; dr <= 1; dr++)
          for (int dc = -1; dc <= 1; dc++)
            if (dr != 0 || dc != 0)
              n += g[(r + dr + ROWS) % ROWS][(c + dc + COLS) % COLS];
        nx[r][c] = (n == 3 || (n == 2 && g[r][c] == 1)) ? 1 : 0;
      end
    end
    g = nx;
  endtask

  task automatic aim(input int r, input int c);
    pix_x = 10'(c * 32 + ((r * 5 + c * 3) % 32));
    pix_y = 10'(r * 32 + ((r * 11 + c) % 32));
  endtask

  task automatic check_grid(input string tag);
    for (int r = 0; r < ROWS; r++) begin
      for (int c = 0; c < COLS; c++) begin
        int exp;
        aim(r, c);
        #1;
        exp = g[r][c] ? 0 : 7;
        chk(int'(pix_rgb) == exp, tag, int'(pix_rgb), exp);
      end
    end
  endtask

  task automatic load_grid();
    for (int r = 0; r < ROWS; r++) begin
      for (int c = 0; c < COLS; c++) begin
        @(negedge clk);
        load_valid = 1'b1;
        load_col   = 5'(c);
        load_row   = 4'(r);
        load_alive = g[r][c][0];
      end
    end
    @(negedge clk);
    load_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    clear_model();
  endtask

  task automatic run_gen(input string tag, input bit poke);
    int lat = 0;
    bit got = 0;
    snap = g;
    model_step();
    @(negedge clk);
    step = 1'b1;
    @(posedge clk);
    #1 step = 1'b0;
    while (!got && lat < 2000) begin
      @(negedge clk);
      lat++;
      if (done) begin
        got = 1;
      end else begin
        if (lat == 10) begin
          chk(busy == 1'b1, "R8 busy during walk", int'(busy), 1);
          chk(load_ready == 1'b0, "R10 ready low while busy", int'(load_ready), 0);
        end
        if (poke) begin
          if (lat == 20) step = 1'b1;          // R9 stray step
          if (lat == 21) step = 1'b0;
          if (lat == 40) begin                 // R10 stray load
            load_valid = 1'b1;
            load_col   = 5'd0;
            load_row   = 4'd0;
            load_alive = !snap[0][0][0];
          end
          if (lat == 41) load_valid = 1'b0;
        end
        if (lat > 60 && lat <= 80) begin
          int e = snap[7][lat - 61] ? 0 : 7;
          chk(int'(pix_rgb) == e, "R7 old view while busy", int'(pix_rgb), e);
        end
        if (lat >= 60 && lat < 80) aim(7, lat - 60);
      end
    end
    // step accepted at edge E0; done set at E300, seen after it
    chk(got && lat == CELLS + 1, "R8 done timing", lat, CELLS + 1);
    @(negedge clk);
    chk(done == 1'b0, "R8 done one cycle", int'(done), 0);
    chk(busy == 1'b0, "R8 idle after walk", int'(busy), 0);
    if (poke) begin
      repeat (5) @(negedge clk);
      chk(busy == 1'b0, "R9 stray step ignored", int'(busy), 0);
    end
    check_grid(tag);
  endtask

  initial begin
    int lfsr;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    clear_model();
    // R11 reset state
    chk(busy == 1'b0, "R11 busy after reset", int'(busy), 0);
    chk(done == 1'b0, "R11 done after reset", int'(done), 0);
    chk(load_ready == 1'b1, "R10 ready when idle", int'(load_ready), 1);
    check_grid("R11 cleared grid");

    // interior blinker
    g[7][9] = 1; g[7][10] = 1; g[7][11] = 1;
    load_grid();
    check_grid("R10 load writes current");
    run_gen("R1 R2 R3 R5 blinker", 1'b1);
    run_gen("R1 R2 R3 R5 blinker back", 1'b0);

    // wrap: blinkers across edges and block across corners
    clear_model();
    g[5][19] = 1; g[5][0] = 1; g[5][1] = 1;
    g[14][10] = 1; g[0][10] = 1; g[1][10] = 1;
    g[0][0] = 1; g[0][19] = 1; g[14][0] = 1; g[14][19] = 1;
    load_grid();
    run_gen("R4 wrap gen1", 1'b0);
    run_gen("R4 wrap gen2", 1'b1);

    // glider through the corner
    clear_model();
    g[12][17] = 1; g[13][18] = 1; g[14][16] = 1; g[14][17] = 1; g[14][18] = 1;
    load_grid();
    for (int i = 0; i < 12; i++) run_gen("R4 R5 glider", 1'b0);

    // pseudo-random field
    lfsr = 32'h1ACE;
    for (int r = 0; r < ROWS; r++) begin
      for (int c = 0; c < COLS; c++) begin
        lfsr = (lfsr * 1103515245 + 12345) & 32'h7fffffff;
        g[r][c] = ((lfsr >> 16) % 3 == 0) ? 1 : 0;
      end
    end
    load_grid();
    for (int i = 0; i < 5; i++) run_gen("R1 R2 R3 R5 random", 1'b0);

    // all live: out-of-range pixels, then overcrowding
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) g[r][c] = 1;
    load_grid();
    check_grid("R6 all live colour");
    pix_x = 10'd650;  pix_y = 10'd40;  #1;
    chk(pix_rgb == 3'b111, "R6 column 20", int'(pix_rgb), 7);
    pix_x = 10'd1023; pix_y = 10'd100; #1;
    chk(pix_rgb == 3'b111, "R6 column 31", int'(pix_rgb), 7);
    pix_x = 10'd100;  pix_y = 10'd490; #1;
    chk(pix_rgb == 3'b111, "R6 row 15", int'(pix_rgb), 7);
    pix_x = 10'd100;  pix_y = 10'd600; #1;
    chk(pix_rgb == 3'b111, "R6 pix_y bit 9", int'(pix_rgb), 7);
    pix_x = 10'd639;  pix_y = 10'd479; #1;
    chk(pix_rgb == 3'b000, "R6 last cell live", int'(pix_rgb), 0);
    run_gen("R2 overcrowding", 1'b0);

    // reset clears both copies
    g[3][3] = 1; g[3][4] = 1; g[3][5] = 1;
    load_grid();
    do_reset();
    chk(busy == 1'b0 && done == 1'b0, "R11 idle after reset", int'(busy), 0);
    check_grid("R11 reset clears current");
    run_gen("R11 reset clears next", 1'b0);

    finish_run();
  end
endmodule